// File: doc/BRIEF.md
# Indirect Data Address Generator

This block forms the memory address for every load, store and constant-fetch instruction of a small 8-bit core. The core has thirty-two byte registers. Three 16-bit pointers are built from the top six of them: X from r27:r26, Y from r29:r28 and Z from r31:r30, with the odd-numbered register as the high byte. The decoder sends an already-decoded addressing mode and pointer choice. The block then returns a data-memory address or a program-memory word address. For the auto-modifying modes it also returns a pointer write-back value with its enable.

The block is purely combinational and completes in a single cycle. The register file takes the write-back on the same clock edge that finishes the access. A pre-decrement therefore uses the lowered pointer for the access and stores that same lowered value. A post-increment uses the old pointer for the access and stores the raised value. All pointer arithmetic wraps modulo 2^16.

Top module: `ptr_agen`

## Requirements
- R1: Mode code 1 (direct) drives `dm_en`=1 and `dm_addr`=`dir_word` and keeps `wb_en`=0.
- R2: Mode code 2 (indirect) drives `dm_addr` with the pointer chosen by `ptr_sel`: 0 gives X={r27,r26}, 1 gives Y={r29,r28}, 2 or 3 gives Z={r31,r30}. `wb_en` stays 0.
- R3: Mode code 3 (displacement) drives `dm_addr`=base+`disp`, where `disp` is an unsigned 6-bit value (0..63). The base is Y when `disp_z`=0 and Z when `disp_z`=1, and `ptr_sel` is ignored. `wb_en` stays 0.
- R4: Mode code 4 (pre-decrement) drives `dm_addr`=ptr-1 and `wb_val`=ptr-1, with `wb_en`=1 and `wb_sel`=`ptr_sel` (3 reported as 2).
- R5: Mode code 5 (post-increment) drives `dm_addr`=ptr and `wb_val`=ptr+1, with `wb_en`=1 and `wb_sel`=`ptr_sel` (3 reported as 2).
- R6: All arithmetic wraps at 16 bits. Pre-decrement of 0x0000 gives 0xFFFF, post-increment of 0xFFFF writes back 0x0000, and the displacement sum wraps.
- R7: Mode code 6 (program constant) drives `pm_en`=1, `pm_word`=Z[15:1] and `pm_hi`=Z[0], where 1 selects the high byte. It keeps `dm_en`=0, `wb_en`=0 and `dm_addr`=0.
- R8: Mode code 0 or 7 (idle) drives every enable, address and write-back output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 3 | Decoded addressing mode (codes in R1..R8) |
| ptr_sel | input | 2 | Pointer choice for indirect and auto-modify modes |
| disp_z | input | 1 | Base choice for displacement mode: 0 = Y, 1 = Z |
| disp | input | 6 | Unsigned displacement |
| dir_word | input | 16 | Second instruction word for direct mode |
| r26 | input | 8 | X low byte |
| r27 | input | 8 | X high byte |
| r28 | input | 8 | Y low byte |
| r29 | input | 8 | Y high byte |
| r30 | input | 8 | Z low byte |
| r31 | input | 8 | Z high byte |
| dm_en | output | 1 | Data-memory access active |
| dm_addr | output | 16 | Data-memory byte address |
| pm_en | output | 1 | Program-memory constant access active |
| pm_word | output | 15 | Program-memory word address |
| pm_hi | output | 1 | Byte select within the program word (1 = high) |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to write back: 0 = X, 1 = Y, 2 = Z |
| wb_val | output | 16 | New pointer value |

## Verification
In the auto-modifying modes, the address for the current access and the pointer write-back are both produced in the same cycle. The hazard is that the two end up ordered the wrong way round. The bench creates this overlap in every pre-decrement and post-increment vector, at ordinary values and at the 0x0000 and 0xFFFF wrap points. In each case it checks that the address equals the write-back value when the decrement comes first, and that it equals the old pointer, one below the write-back, when the increment comes after.

// File: rtl/ptr_agen.sv
module ptr_agen #(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    ptr_sel,
  input  logic          disp_z,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] dir_word,
  input  logic [7:0]    r26,
  input  logic [7:0]    r27,
  input  logic [7:0]    r28,
  input  logic [7:0]    r29,
  input  logic [7:0]    r30,
  input  logic [7:0]    r31,
  output logic          dm_en,
  output logic [AW-1:0] dm_addr,
  output logic          pm_en,
  output logic [AW-2:0] pm_word,
  output logic          pm_hi,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);

  localparam logic [2:0] M_DIR  = 3'd1;
  localparam logic [2:0] M_IND  = 3'd2;
  localparam logic [2:0] M_DISP = 3'd3;
  localparam logic [2:0] M_PRE  = 3'd4;
  localparam logic [2:0] M_POST = 3'd5;
  localparam logic [2:0] M_PROG = 3'd6;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] px, py, pz, sel_ptr, base, dsum;
  logic [1:0]    sel_n;

  assign px = {r27, r26};
  assign py = {r29, r28};
  assign pz = {r31, r30};

  assign sel_n   = ptr_sel[1] ? 2'd2 : ptr_sel;
  assign sel_ptr = (sel_n == 2'd0) ? px : (sel_n == 2'd1) ? py : pz;
  assign base    = disp_z ? pz : py;
  assign dsum    = base + AW'(disp);

  always_comb begin
    dm_en   = 1'b0;
    dm_addr = '0;
    case (mode)
      M_DIR:  begin dm_en = 1'b1; dm_addr = dir_word;      end
      M_IND:  begin dm_en = 1'b1; dm_addr = sel_ptr;       end
      M_DISP: begin dm_en = 1'b1; dm_addr = dsum;          end
      M_PRE:  begin dm_en = 1'b1; dm_addr = sel_ptr - ONE; end
      M_POST: begin dm_en = 1'b1; dm_addr = sel_ptr;       end
      default: ;
    endcase
  end

  always_comb begin
    wb_en  = 1'b0;
    wb_sel = 2'd0;
    wb_val = '0;
    if (mode == M_PRE) begin
      wb_en  = 1'b1;
      wb_sel = sel_n;
      wb_val = sel_ptr - ONE;
    end else if (mode == M_POST) begin
      wb_en  = 1'b1;
      wb_sel = sel_n;
      wb_val = sel_ptr + ONE;
    end
  end

  assign pm_en   = (mode == M_PROG);
  assign pm_word = pm_en ? pz[AW-1:1] : '0;
  assign pm_hi   = pm_en & pz[0];

  always_comb begin
    if (mode == M_PRE)
      a_r4_pre_addr_is_wb: assert (wb_en && wb_val == dm_addr)
        else $error("R4 pre-decrement address differs from write-back");
    if (mode == M_POST)
      a_r5_post_wb_above_addr: assert (wb_en && wb_val == dm_addr + ONE)
        else $error("R5 post-increment write-back not one above address");
    if (mode == M_IND || mode == M_DISP || mode == M_DIR)
      a_r2_r3_no_writeback: assert (!wb_en && dm_en)
        else $error("R2/R3 non-modifying mode asserted write-back");
    a_r7_one_space: assert (!(dm_en && pm_en))
      else $error("R7 data and program access at once");
    if (mode == 3'd0 || mode == 3'd7)
      a_r8_idle_quiet: assert (!dm_en && !pm_en && !wb_en && dm_addr == '0)
        else $error("R8 idle mode drove an output");
  end

endmodule

// File: tb/sim_ptr_agen.sv
`timescale 1ns/1ps
module sim_ptr_agen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic        disp_z;
  logic [5:0]  disp;
  logic [15:0] dir_word, X, Y, Z;
  logic        dm_en, pm_en, pm_hi, wb_en;
  logic [15:0] dm_addr, wb_val;
  logic [14:0] pm_word;
  logic [1:0]  wb_sel;

  int tests = 0;
  int fails = 0;

  ptr_agen u0 (
    .mode(mode), .ptr_sel(ptr_sel), .disp_z(disp_z), .disp(disp), .dir_word(dir_word),
    .r26(X[7:0]), .r27(X[15:8]), .r28(Y[7:0]), .r29(Y[15:8]), .r30(Z[7:0]), .r31(Z[15:8]),
    .dm_en(dm_en), .dm_addr(dm_addr), .pm_en(pm_en), .pm_word(pm_word), .pm_hi(pm_hi),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  m;
    logic [1:0]  s;
    logic        dz;
    logic [5:0]  q;
    logic [15:0] dw, px, py, pz;
    logic        e_dm;
    logic [15:0] e_addr;
    logic        e_pm;
    logic [14:0] e_pw;
    logic        e_ph;
    logic        e_wb;
    logic [1:0]  e_ws;
    logic [15:0] e_wv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{8'd1, 3'd1, 2'd0, 1'b0, 6'h00, 16'hBEEF, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'hBEEF, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R1
    '{8'd2, 3'd2, 2'd0, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h1234, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R2 X
    '{8'd2, 3'd2, 2'd1, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h5678, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R2 Y
    '{8'd2, 3'd2, 2'd2, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h9ABD, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R2 Z
    '{8'd2, 3'd2, 2'd3, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h9ABD, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R2 sel 3
    '{8'd3, 3'd3, 2'd0, 1'b0, 6'h3F, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h56B7, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R3 Y+63
    '{8'd3, 3'd3, 2'd1, 1'b1, 6'h01, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h9ABE, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R3 Z+1
    '{8'd3, 3'd3, 2'd2, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h5678, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R3 q=0
    '{8'd4, 3'd4, 2'd1, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h5677, 1'b0, 15'h0, 1'b0, 1'b1, 2'd1, 16'h5677}, // R4 Y
    '{8'd4, 3'd4, 2'd3, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h9ABC, 1'b0, 15'h0, 1'b0, 1'b1, 2'd2, 16'h9ABC}, // R4 Z
    '{8'd5, 3'd5, 2'd0, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b1, 16'h1234, 1'b0, 15'h0, 1'b0, 1'b1, 2'd0, 16'h1235}, // R5 X
    '{8'd6, 3'd4, 2'd1, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h0000, 16'h9ABD, 1'b1, 16'hFFFF, 1'b0, 15'h0, 1'b0, 1'b1, 2'd1, 16'hFFFF}, // R6 pre 0
    '{8'd6, 3'd5, 2'd2, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0, 15'h0, 1'b0, 1'b1, 2'd2, 16'h0000}, // R6 post FFFF
    '{8'd6, 3'd3, 2'd0, 1'b1, 6'h3F, 16'h0000, 16'h1234, 16'h5678, 16'hFFF0, 1'b1, 16'h002F, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 16'h0}, // R6 disp wrap
    '{8'd7, 3'd6, 2'd0, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h9ABD, 1'b0, 16'h0000, 1'b1, 15'h4D5E, 1'b1, 1'b0, 2'd0, 16'h0}, // R7 odd
    '{8'd7, 3'd6, 2'd1, 1'b0, 6'h00, 16'h0000, 16'h1234, 16'h5678, 16'h0100, 1'b0, 16'h0000, 1'b1, 15'h0080, 1'b0, 1'b0, 2'd0, 16'h0}  // R7 even
  };

  task automatic apply(input vec_t v);
    @(negedge clk);
    mode = v.m; ptr_sel = v.s; disp_z = v.dz; disp = v.q; dir_word = v.dw;
    X = v.px; Y = v.py; Z = v.pz;
    @(posedge clk); #1;
  endtask

  task automatic judge(input vec_t v);
    logic [53:0] act, exp;
    act = {dm_en, dm_addr, pm_en, pm_word, pm_hi, wb_en, wb_sel, wb_val};
    exp = {v.e_dm, v.e_addr, v.e_pm, v.e_pw, v.e_ph, v.e_wb, v.e_ws, v.e_wv};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d mode=%0d actual=%h expected=%h", v.req, v.m, act, exp);
    end
  endtask

  initial begin
    vec_t idle;
    idle = '0;
    idle.req = 8'd8;
    mode = 3'd0; ptr_sel = 2'd0; disp_z = 1'b0; disp = '0; dir_word = '0;
    X = 16'h1111; Y = 16'h2222; Z = 16'h3333;
    repeat (3) @(posedge clk);
    #1;
    idle.px = X; idle.py = Y; idle.pz = Z;
    judge(idle); // R8 reset-time idle
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      judge(VT[i]);
    end

    idle.m = 3'd7; idle.dw = 16'hFFFF; idle.s = 2'd2; idle.pz = 16'hFFFF;
    apply(idle);
    judge(idle); // R8 code 7 with live inputs

    idle.m = 3'd0; idle.dz = 1'b1; idle.q = 6'h3F;
    apply(idle);
    judge(idle); // R8 code 0

    begin
      vec_t v;
      v = VT[0];
      v.req = 8'd1; v.dw = 16'h0000;
      v.e_addr = 16'h0000;
      apply(v);
      judge(v); // R1 direct zero word
      v.dw = 16'hFFFF; v.e_addr = 16'hFFFF;
      apply(v);
      judge(v); // R1 direct all ones
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #50000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule